// File: doc/BRIEF.md
# Start-time fair queuing scheduler

This block decides which flow's head packet goes next over a small fixed set of flows (four by default), using start-time fair queuing. It holds only tags and never packet data. An arrival names a flow and a packet length. The block gives the packet a start tag and a finish tag. The start tag joins that flow's tag queue, and the finish tag becomes the flow's carried-over finish value. A dequeue request is answered one cycle later, either with the flow whose head packet has the smallest start tag or with a "nothing queued" pulse.

Each flow has a weight, held as a preloaded fixed-point reciprocal with 8 fractional bits. The finish tag is therefore the start tag plus (length × reciprocal) >> 8, and no divider is needed. The scheduler keeps a server virtual time. Inside a busy period it follows the start tag of the packet most recently granted. When a busy period ends it jumps to the largest finish tag issued so far.

A two-state machine tracks the busy period:

- `ST_IDLE`: nothing is queued and nothing is in service.
- `ST_BUSY`: packets are queued or in service.

It has two transitions:

- *open* (`ST_IDLE` → `ST_BUSY`): an arrival is accepted.
- *drain* (`ST_BUSY` → `ST_IDLE`): a dequeue request finds every queue empty and no arrival is accepted in that cycle.

Top module: `sfq_sched`

## Requirements
- R1: After reset, `virt_time` is 0, every carried-over finish tag is 0, every reciprocal is 256 (weight 1.0), `arr_ready` is high and `gnt_valid`, `gnt_none` and `arr_err` are low.
- R2: An accepted arrival gets start tag = max(virt_time at that cycle, the flow's carried-over finish tag). Before a flow's first packet, that finish tag is 0.
- R3: The finish tag is start + ((len × inv) >> 8), truncated to 32 bits, where inv is the flow's reciprocal. A write on the config port changes the reciprocal used by arrivals in later cycles.
- R4: A dequeue request in cycle t yields, in cycle t+1, exactly one pulse: either `gnt_valid`, carrying the flow whose head has the smallest start tag and that tag, or `gnt_none` when every queue is empty. Equal tags go to the lowest flow index.
- R5: When a grant is reported, `virt_time` equals the granted start tag. `virt_time` never decreases.
- R6: A dequeue in `ST_BUSY` that finds every queue empty, with no accepted arrival in the same cycle, takes the drain transition and sets `virt_time` to the largest finish tag issued so far. No grant is reported in `ST_IDLE`.
- R7: Each flow queue holds 8 tags. `arr_ready` is low while the addressed flow's queue is full. A refused arrival (`arr_valid` with `arr_ready` low) raises `arr_err` for one cycle in the next cycle and changes no tag state.
- R8: When an arrival and a dequeue share a cycle, the arrival uses `virt_time` from before that cycle's update, and the grant choice sees only packets queued before that cycle.
- R9: Within one flow, tags leave in arrival order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Write a flow's reciprocal weight |
| cfg_flow | input | 2 | Flow addressed by the config write |
| cfg_inv | input | 16 | Reciprocal weight, 8 fractional bits |
| arr_valid | input | 1 | Arrival offered |
| arr_ready | output | 1 | Addressed flow queue has room |
| arr_flow | input | 2 | Arriving packet's flow |
| arr_len | input | 16 | Arriving packet's length |
| arr_err | output | 1 | Pulse: previous-cycle arrival refused |
| deq_valid | input | 1 | Dequeue request |
| deq_ready | output | 1 | Always high; a request is taken every cycle |
| gnt_valid | output | 1 | Pulse: grant reported |
| gnt_none | output | 1 | Pulse: request found all queues empty |
| gnt_flow | output | 2 | Granted flow |
| gnt_tag | output | 32 | Start tag of the granted packet |
| virt_time | output | 32 | Server virtual time |

## Verification
An arrival and a dequeue request can land in the same cycle. The arrival then reads the virtual time that the grant is about to overwrite, and it may target the very flow being popped or a flow that is still empty. A long mixed phase drives both handshakes from independent pseudo-random bits, so these coincidences happen often, including on full queues and on the drain cycle. An arithmetic model in the bench uses the pre-update virtual time and the pre-arrival queue heads, and it judges every cycle's grant, tag, error pulse and virtual time against that model.

// File: rtl/sfq_pkg.sv
package sfq_pkg;

    // Busy-period tracking states
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_BUSY = 1'b1
    } sched_state_e;

endpackage

// File: rtl/sfq_tag_fifo.sv
// Per-flow start-tag queue; push and pop may share a cycle (R9 order).
module sfq_tag_fifo #(
    parameter int DEPTH = 8,
    parameter int W     = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         empty,
    output logic         full
);
    localparam int AW = $clog2(DEPTH);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [AW:0]   count;

    logic do_push, do_pop;

    assign empty   = (count == '0);
    assign full    = (count == (AW+1)'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wr_ptr] <= push_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) begin
                wr_ptr <= wr_ptr + 1'b1;
            end
            if (do_pop) begin
                rd_ptr <= rd_ptr + 1'b1;
            end
            unique case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/sfq_tag_calc.sv
// Start/finish tag arithmetic for one arrival (R2, R3).
module sfq_tag_calc #(
    parameter int TAG_W  = 32,
    parameter int LEN_W  = 16,
    parameter int INV_W  = 16,
    parameter int FRAC_W = 8
) (
    input  logic [TAG_W-1:0] vnow,
    input  logic [TAG_W-1:0] prev_fin,
    input  logic [LEN_W-1:0] len,
    input  logic [INV_W-1:0] inv,
    output logic [TAG_W-1:0] start_tag,
    output logic [TAG_W-1:0] finish_tag
);
    localparam int PROD_W = LEN_W + INV_W;

    logic [PROD_W-1:0] prod;
    logic [PROD_W-1:0] scaled;
    logic [TAG_W-1:0]  incr;

    always_comb begin
        prod       = PROD_W'(len) * PROD_W'(inv);
        scaled     = prod >> FRAC_W;
        incr       = TAG_W'(scaled);
        start_tag  = (vnow > prev_fin) ? vnow : prev_fin;
        finish_tag = start_tag + incr;
    end
endmodule

// File: rtl/sfq_min_pick.sv
// Smallest head start tag among non-empty flows; ties to the lowest index (R4).
module sfq_min_pick #(
    parameter int N  = 4,
    parameter int W  = 32,
    parameter int IW = 2
) (
    input  logic [N-1:0]        vld,
    input  logic [N-1:0][W-1:0] tags,
    output logic                found,
    output logic [IW-1:0]       idx,
    output logic [W-1:0]        tag
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        tag   = '0;
        for (int i = 0; i < N; i++) begin
            if (vld[i] && (!found || (tags[i] < tag))) begin
                found = 1'b1;
                idx   = IW'(i);
                tag   = tags[i];
            end
        end
    end
endmodule

// File: rtl/sfq_sched.sv
module sfq_sched
    import sfq_pkg::*;
#(
    parameter  int NUM_FLOWS  = 4,
    parameter  int FIFO_DEPTH = 8,
    parameter  int TAG_W      = 32,
    parameter  int LEN_W      = 16,
    parameter  int INV_W      = 16,
    parameter  int FRAC_W     = 8,
    localparam int FLOW_W     = $clog2(NUM_FLOWS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [FLOW_W-1:0] cfg_flow,
    input  logic [INV_W-1:0]  cfg_inv,
    input  logic              arr_valid,
    output logic              arr_ready,
    input  logic [FLOW_W-1:0] arr_flow,
    input  logic [LEN_W-1:0]  arr_len,
    output logic              arr_err,
    input  logic              deq_valid,
    output logic              deq_ready,
    output logic              gnt_valid,
    output logic              gnt_none,
    output logic [FLOW_W-1:0] gnt_flow,
    output logic [TAG_W-1:0]  gnt_tag,
    output logic [TAG_W-1:0]  virt_time
);
    localparam logic [INV_W-1:0] INV_ONE = INV_W'(1 << FRAC_W);

    sched_state_e state_q, state_d;

    logic [NUM_FLOWS-1:0]            fifo_empty, fifo_full, fifo_push, fifo_pop;
    logic [NUM_FLOWS-1:0][TAG_W-1:0] fifo_head;
    logic [NUM_FLOWS-1:0][INV_W-1:0] inv_q;
    logic [NUM_FLOWS-1:0][TAG_W-1:0] last_fin_q;

    logic [TAG_W-1:0]  vtime_q, max_fin_q;
    logic [TAG_W-1:0]  new_start, new_finish, pick_tag;
    logic              pick_found;
    logic [FLOW_W-1:0] pick_idx;
    logic              arr_acc, deq_hit, drain;

    // Handshake decode (R7): refusal only when the addressed queue is full
    assign arr_ready = ~fifo_full[arr_flow];
    assign deq_ready = 1'b1;
    assign arr_acc   = arr_valid & arr_ready;
    assign deq_hit   = deq_valid & pick_found;
    // R6: the busy period ends on an empty request with no arrival
    assign drain     = (state_q == ST_BUSY) & deq_valid & ~pick_found & ~arr_acc;
    assign virt_time = vtime_q;

    // Per-flow tag queues
    for (genvar g = 0; g < NUM_FLOWS; g++) begin : g_flow
        assign fifo_push[g] = arr_acc && (arr_flow == FLOW_W'(g));
        assign fifo_pop[g]  = deq_hit && (pick_idx == FLOW_W'(g));

        sfq_tag_fifo #(
            .DEPTH (FIFO_DEPTH),
            .W     (TAG_W)
        ) u_fifo (
            .clk       (clk),
            .rst_n     (rst_n),
            .push      (fifo_push[g]),
            .push_data (new_start),
            .pop       (fifo_pop[g]),
            .head      (fifo_head[g]),
            .empty     (fifo_empty[g]),
            .full      (fifo_full[g])
        );
    end

    // R2/R3/R8: tags use the virtual time before this cycle's update
    sfq_tag_calc #(
        .TAG_W  (TAG_W),
        .LEN_W  (LEN_W),
        .INV_W  (INV_W),
        .FRAC_W (FRAC_W)
    ) u_calc (
        .vnow       (vtime_q),
        .prev_fin   (last_fin_q[arr_flow]),
        .len        (arr_len),
        .inv        (inv_q[arr_flow]),
        .start_tag  (new_start),
        .finish_tag (new_finish)
    );

    sfq_min_pick #(
        .N  (NUM_FLOWS),
        .W  (TAG_W),
        .IW (FLOW_W)
    ) u_pick (
        .vld   (~fifo_empty),
        .tags  (fifo_head),
        .found (pick_found),
        .idx   (pick_idx),
        .tag   (pick_tag)
    );

    // Next state: open on accepted arrival, drain on empty request
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (arr_acc) state_d = ST_BUSY;
            ST_BUSY: if (drain)   state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Tag bookkeeping and virtual time (R1, R3, R5, R6)
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vtime_q    <= '0;
            max_fin_q  <= '0;
            last_fin_q <= '0;
            for (int i = 0; i < NUM_FLOWS; i++) begin
                inv_q[i] <= INV_ONE;
            end
        end else begin
            if (cfg_we) begin
                inv_q[cfg_flow] <= cfg_inv;
            end
            if (arr_acc) begin
                last_fin_q[arr_flow] <= new_finish;
                if (new_finish > max_fin_q) begin
                    max_fin_q <= new_finish;
                end
            end
            if (deq_hit) begin
                vtime_q <= pick_tag;
            end else if (drain) begin
                vtime_q <= max_fin_q;
            end
        end
    end

    // Registered responses (R4, R7)
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gnt_valid <= 1'b0;
            gnt_none  <= 1'b0;
            gnt_flow  <= '0;
            gnt_tag   <= '0;
            arr_err   <= 1'b0;
        end else begin
            gnt_valid <= deq_hit;
            gnt_none  <= deq_valid & ~pick_found;
            arr_err   <= arr_valid & ~arr_ready;
            if (deq_hit) begin
                gnt_flow <= pick_idx;
                gnt_tag  <= pick_tag;
            end
        end
    end
endmodule

// File: rtl/sfq_sched_checker.sv
module sfq_sched_checker
    import sfq_pkg::*;
#(
    parameter int TAG_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             arr_valid,
    input logic             arr_ready,
    input logic             arr_err,
    input logic             deq_valid,
    input logic             gnt_valid,
    input logic             gnt_none,
    input logic [TAG_W-1:0] gnt_tag,
    input logic [TAG_W-1:0] virt_time,
    input sched_state_e     state
);
    a_r4_one_response: assert property (@(posedge clk) disable iff (!rst_n)
        deq_valid |=> (gnt_valid != gnt_none));

    a_r4_no_unasked: assert property (@(posedge clk) disable iff (!rst_n)
        !deq_valid |=> (!gnt_valid && !gnt_none));

    a_r7_err_when_refused: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_valid && !arr_ready) |=> arr_err);

    a_r7_err_only_refused: assert property (@(posedge clk) disable iff (!rst_n)
        (!arr_valid || arr_ready) |=> !arr_err);

    a_r5_vtime_is_grant: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_valid |-> (virt_time == gnt_tag));

    a_r5_vtime_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
        virt_time >= $past(virt_time));

    a_r6_no_grant_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> !gnt_valid);
endmodule

bind sfq_sched sfq_sched_checker #(.TAG_W(TAG_W)) u_sfq_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .arr_valid (arr_valid),
    .arr_ready (arr_ready),
    .arr_err   (arr_err),
    .deq_valid (deq_valid),
    .gnt_valid (gnt_valid),
    .gnt_none  (gnt_none),
    .gnt_tag   (gnt_tag),
    .virt_time (virt_time),
    .state     (state_q)
);

// File: tb/sfq_sched_bench.sv
`timescale 1ns/1ps
module sfq_sched_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_flow = '0;
    logic [15:0] cfg_inv = '0;
    logic        arr_valid = 1'b0;
    logic        arr_ready;
    logic [1:0]  arr_flow = '0;
    logic [15:0] arr_len = '0;
    logic        arr_err;
    logic        deq_valid = 1'b0;
    logic        deq_ready;
    logic        gnt_valid, gnt_none;
    logic [1:0]  gnt_flow;
    logic [31:0] gnt_tag, virt_time;

    int errors = 0;
    int checks = 0;

    // Bench model state
    logic [31:0] mq [4][8];
    int          mcnt [4];
    logic [31:0] m_lf [4];
    logic [31:0] m_inv [4];
    logic [31:0] m_vt, m_maxfin;
    bit          m_busy;
    logic [31:0] seed = 32'h1234_5678;

    always #4 clk = ~clk;

    sfq_sched u_sfq_sched (
        .clk (clk), .rst_n (rst_n),
        .cfg_we (cfg_we), .cfg_flow (cfg_flow), .cfg_inv (cfg_inv),
        .arr_valid (arr_valid), .arr_ready (arr_ready), .arr_flow (arr_flow),
        .arr_len (arr_len), .arr_err (arr_err),
        .deq_valid (deq_valid), .deq_ready (deq_ready),
        .gnt_valid (gnt_valid), .gnt_none (gnt_none), .gnt_flow (gnt_flow),
        .gnt_tag (gnt_tag), .virt_time (virt_time)
    );

    initial begin
        #(8 * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    task automatic chk(input bit ok, input string what, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    function automatic logic [31:0] rnd();
        seed = seed * 32'd1103515245 + 32'd12345;
        return seed;
    endfunction

    task automatic cfg(input int f, input int inv);
        @(negedge clk);
        cfg_we = 1'b1; cfg_flow = f[1:0]; cfg_inv = inv[15:0];
        @(posedge clk);
        #2;
        cfg_we = 1'b0;
        m_inv[f] = inv;
    endtask

    // One cycle of stimulus, model update and comparison
    task automatic step(input bit av, input int af, input int al, input bit dv, input string ph);
        bit          exp_rdy, acc, found, drain;
        int          bi;
        logic [31:0] bt, st, fn;
        longint      incr;
        @(negedge clk);
        arr_valid = av; arr_flow = af[1:0]; arr_len = al[15:0]; deq_valid = dv;
        #1;
        exp_rdy = (mcnt[af] < 8);
        chk(arr_ready == exp_rdy, {ph, " R7 arr_ready"}, arr_ready, exp_rdy);
        acc = av && exp_rdy;
        found = 0; bi = 0; bt = 0;
        for (int f = 0; f < 4; f++) begin
            if (mcnt[f] > 0 && (!found || mq[f][0] < bt)) begin
                found = 1; bi = f; bt = mq[f][0];
            end
        end
        st = (m_vt > m_lf[af]) ? m_vt : m_lf[af];
        incr = (longint'(al) * longint'(m_inv[af])) >>> 8;
        fn = st + incr[31:0];
        drain = dv && !found && m_busy && !acc;
        @(posedge clk);
        #2;
        arr_valid = 1'b0; deq_valid = 1'b0;
        // model update
        if (dv && found) begin
            for (int k = 0; k < 7; k++) mq[bi][k] = mq[bi][k+1];
            mcnt[bi]--;
            m_vt = bt;
        end else if (drain) begin
            m_vt = m_maxfin;
        end
        if (acc) begin
            mq[af][mcnt[af]] = st;
            mcnt[af]++;
            m_lf[af] = fn;
            if (fn > m_maxfin) m_maxfin = fn;
            m_busy = 1;
        end else if (drain) begin
            m_busy = 0;
        end
        chk(gnt_valid == (dv && found), {ph, " R4 gnt_valid"}, gnt_valid, dv && found);
        chk(gnt_none == (dv && !found), {ph, " R4 gnt_none"}, gnt_none, dv && !found);
        if (dv && found) begin
            chk(gnt_flow == bi[1:0], {ph, " R4 gnt_flow"}, gnt_flow, bi);
            chk(gnt_tag == bt, {ph, " R2 R3 R9 gnt_tag"}, gnt_tag, bt);
        end
        chk(arr_err == (av && !exp_rdy), {ph, " R7 arr_err"}, arr_err, av && !exp_rdy);
        chk(virt_time == m_vt, {ph, " R5 R6 virt_time"}, virt_time, m_vt);
    endtask

    initial begin
        for (int f = 0; f < 4; f++) begin
            mcnt[f] = 0; m_lf[f] = 0; m_inv[f] = 256;
        end
        m_vt = 0; m_maxfin = 0; m_busy = 0;
        repeat (5) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        chk(arr_ready == 1'b1, "R1 arr_ready", arr_ready, 1);
        chk(gnt_valid == 1'b0, "R1 gnt_valid", gnt_valid, 0);
        chk(gnt_none == 1'b0, "R1 gnt_none", gnt_none, 0);
        chk(arr_err == 1'b0, "R1 arr_err", arr_err, 0);
        chk(virt_time == 32'd0, "R1 virt_time", virt_time, 0);

        // R1 default reciprocal of 256: flow 0, len 40 -> finish 40
        step(1, 0, 40, 0, "R1 default weight");
        step(0, 0, 0, 1, "R1 default weight");
        step(0, 0, 0, 1, "R6 drain to 40");

        // R3 weights through the config port
        cfg(0, 256); cfg(1, 512); cfg(2, 128); cfg(3, 256);
        step(0, 0, 0, 1, "R6 idle empty request");

        // R4 tie: both start at virt_time, flow 1 beats flow 3
        step(1, 3, 100, 0, "R4 tie");
        step(1, 1, 100, 0, "R4 tie");
        step(0, 0, 0, 1, "R4 tie");
        step(0, 0, 0, 1, "R4 tie");
        step(0, 0, 0, 1, "R6 drain");

        // R2 R3 R9 sweep over flows and lengths, then drain
        for (int f = 0; f < 4; f++)
            for (int k = 0; k < 4; k++)
                step(1, f, 64 * (k + 1) + 10 * f, 0, "R2 R9 sweep");
        for (int n = 0; n < 17; n++) step(0, 0, 0, 1, "R4 R9 sweep drain");

        // R7 fill flow 2 and refuse the ninth arrival
        for (int n = 0; n < 9; n++) step(1, 2, 30 + n, 0, "R7 fill");
        for (int n = 0; n < 10; n++) step(0, 0, 0, 1, "R7 drain");

        // R3 reconfiguration affects later arrivals
        cfg(0, 1024);
        step(1, 0, 50, 0, "R3 new weight");
        step(1, 0, 50, 0, "R3 new weight");
        for (int n = 0; n < 3; n++) step(0, 0, 0, 1, "R3 new weight");

        // R8 mixed arrivals and requests in the same cycles
        for (int n = 0; n < 3000; n++) begin
            logic [31:0] r;
            r = rnd();
            if (n % 500 == 250) cfg(int'(r[5:4]), 64 + int'(r[13:6]) * 4);
            step(r[17] | r[18], int'(r[20:19]), 1 + int'(r[31:22]), r[21] & r[23], "R8 mixed");
        end
        for (int n = 0; n < 40; n++) step(0, 0, 0, 1, "R8 final drain");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule